// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block takes two IEEE 754 binary64 bit patterns and reduces their relation to a three-bit condition code that a branch unit can test directly. There are four possible relations: greater, less, equal and unordered. They are mapped onto zero, parity and carry flags. The "unordered" relation sets all three flags, so a branch taken only on "carry clear and zero clear" is taken for a strict greater-than and for nothing else. The same relation is also driven out as three legacy status-word condition bits.

Operands are ordered as sign-magnitude numbers. Once the sign bit is removed, the exponent and fraction field of each operand is compared as an unsigned integer. For negative operands that ordering is reversed. The two zeros compare equal. Subnormal inputs are compared exactly, unless the per-operation flush control is set. In that case each subnormal operand is taken as a zero of the same sign. A second per-operation control chooses between two compare variants. In the signalling variant, any NaN operand raises the invalid indication. In the quiet variant, only a signalling NaN raises it.

The operand interface is valid/ready and holds a single result register. A new operation is accepted while the register is empty or while its result is being consumed in that same cycle. The result stays valid until the consumer takes it. The flags keep their value after that until the next operation is accepted.

Top module: `fpc_flags`

## Requirements
- R1: When either operand is a NaN (exponent all ones, fraction nonzero), the result is unordered, and flag_zero, flag_parity and flag_carry are all 1.
- R2: When operand A is greater than operand B, all three flags are 0.
- R3: When A is less than B, only flag_carry is 1. When A equals B, only flag_zero is 1. flag_parity is 0 for every ordered result.
- R4: Operands are ordered as sign-magnitude values. A negative value is below every positive value, and between two negative values the one with the larger magnitude field is the smaller. For example, -1.0 is greater than -2.0.
- R5: +0 and -0 compare equal.
- R6: With daz=0, subnormal operands are compared exactly. For example, pattern 0x123 is less than pattern 0x124, and a negative subnormal is less than +0.
- R7: With daz=1, each subnormal operand is treated as a zero of its own sign before the compare. Two different subnormals then compare equal, and a negative subnormal equals +0.
- R8: With sig_cmp=1, invalid is 1 whenever either operand is any NaN.
- R9: With sig_cmp=0, invalid is 1 only when an operand is a signalling NaN (fraction MSB clear, bit 51). A quiet NaN gives invalid=0. Ordered operands always give invalid=0.
- R10: The legacy bits follow the flags: sw_c0 equals flag_carry, sw_c2 equals flag_parity and sw_c3 equals flag_zero.
- R11: An operation accepted at a clock edge (in_valid and in_ready both high) has its result on the outputs, with out_valid=1, right after that edge.
- R12: in_ready = !out_valid || out_ready. While out_valid=1 and out_ready=0, the outputs do not change. Once the result is consumed and no new operation is accepted, out_valid drops and the flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| op_a | input | 64 | Operand A, binary64 bit pattern |
| op_b | input | 64 | Operand B, binary64 bit pattern |
| daz | input | 1 | Treat subnormal operands as zero |
| sig_cmp | input | 1 | 1: signalling variant, 0: quiet variant |
| out_valid | output | 1 | Result held for the consumer |
| out_ready | input | 1 | Consumer takes the result |
| flag_zero | output | 1 | Zero flag |
| flag_parity | output | 1 | Parity flag (unordered) |
| flag_carry | output | 1 | Carry flag |
| invalid | output | 1 | Invalid-operation indication |
| sw_c0 | output | 1 | Legacy condition bit C0 |
| sw_c2 | output | 1 | Legacy condition bit C2 |
| sw_c3 | output | 1 | Legacy condition bit C3 |

## Verification
Two events can fall in the same cycle: the consumer taking a held result, and a new operation being accepted into the same register. The bench creates this case by stalling the consumer on a less-than result while a greater-than operation waits at the input. During the stall it checks that the held flags and out_valid do not change. It then raises out_ready for one cycle and expects the greater-than flags with out_valid still high right after that edge, which shows that no result was dropped and no idle cycle was inserted.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  // Relation code; the bit pattern is internal only.
  typedef enum logic [1:0] {
    REL_GT = 2'b00,
    REL_LT = 2'b01,
    REL_EQ = 2'b10,
    REL_UN = 2'b11
  } rel_t;

  typedef struct packed {
    logic sign;
    logic nan;
    logic snan;
    logic zero;
  } opclass_t;
endpackage

// File: rtl/fpc_classify.sv
module fpc_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int MAG_W = EXP_W + FRAC_W,
  localparam int W     = MAG_W + 1
) (
  input  logic [W-1:0]     op,
  input  logic             daz,
  output fpc_pkg::opclass_t cls,
  output logic [MAG_W-1:0] mag
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_max, exp_min, frac_nz, flush;

  always_comb begin
    exp_f   = op[W-2 -: EXP_W];
    frac_f  = op[FRAC_W-1:0];
    exp_max = &exp_f;
    exp_min = ~|exp_f;
    frac_nz = |frac_f;
    flush   = exp_min && (!frac_nz || daz);

    cls.sign = op[W-1];
    cls.nan  = exp_max && frac_nz;
    cls.snan = exp_max && frac_nz && !frac_f[FRAC_W-1];
    cls.zero = flush;
    mag      = flush ? '0 : op[MAG_W-1:0];
  end
endmodule

// File: rtl/fpc_relate.sv
module fpc_relate #(
  parameter int MAG_W = 63
) (
  input  fpc_pkg::opclass_t cls_a,
  input  logic [MAG_W-1:0]  mag_a,
  input  fpc_pkg::opclass_t cls_b,
  input  logic [MAG_W-1:0]  mag_b,
  output fpc_pkg::rel_t     rel
);
  import fpc_pkg::*;
  logic mag_gt, mag_eq;

  always_comb begin
    mag_gt = mag_a > mag_b;
    mag_eq = mag_a == mag_b;
    if (cls_a.nan || cls_b.nan)
      rel = REL_UN;
    else if (cls_a.zero && cls_b.zero)
      rel = REL_EQ;
    else if (cls_a.sign != cls_b.sign)
      rel = cls_a.sign ? REL_LT : REL_GT;
    else if (mag_eq)
      rel = REL_EQ;
    else if (mag_gt ^ cls_a.sign)
      rel = REL_GT;
    else
      rel = REL_LT;
  end
endmodule

// File: rtl/fpc_encode.sv
module fpc_encode #(
  parameter bit LEGACY = 1'b0
) (
  input  fpc_pkg::rel_t rel,
  output logic          bit_zero,
  output logic          bit_par,
  output logic          bit_carry
);
  import fpc_pkg::*;
  generate
    if (LEGACY) begin : g_legacy
      // Status-word form: decoded by case so it is a separate path from the flags.
      always_comb begin
        case (rel)
          REL_LT:  {bit_zero, bit_par, bit_carry} = 3'b001;
          REL_EQ:  {bit_zero, bit_par, bit_carry} = 3'b100;
          REL_UN:  {bit_zero, bit_par, bit_carry} = 3'b111;
          default: {bit_zero, bit_par, bit_carry} = 3'b000;
        endcase
      end
    end else begin : g_flags
      always_comb begin
        bit_zero  = (rel == REL_EQ) || (rel == REL_UN);
        bit_par   = (rel == REL_UN);
        bit_carry = (rel == REL_LT) || (rel == REL_UN);
      end
    end
  endgenerate
endmodule

// File: rtl/fpc_flags.sv
module fpc_flags #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int MAG_W = EXP_W + FRAC_W,
  localparam int W     = MAG_W + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         daz,
  input  logic         sig_cmp,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         flag_zero,
  output logic         flag_parity,
  output logic         flag_carry,
  output logic         invalid,
  output logic         sw_c0,
  output logic         sw_c2,
  output logic         sw_c3
);
  import fpc_pkg::*;

  opclass_t         cls [2];
  logic [MAG_W-1:0] mag [2];
  logic [W-1:0]     ops [2];
  rel_t             rel_d, rel_q;
  logic             inv_d, inv_q, vld_q, accept;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fpc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op(ops[i]), .daz(daz), .cls(cls[i]), .mag(mag[i])
    );
  end

  fpc_relate #(.MAG_W(MAG_W)) u_rel (
    .cls_a(cls[0]), .mag_a(mag[0]), .cls_b(cls[1]), .mag_b(mag[1]), .rel(rel_d)
  );

  always_comb begin
    inv_d = sig_cmp ? (cls[0].nan || cls[1].nan) : (cls[0].snan || cls[1].snan);
  end

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= REL_GT;
      inv_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      if (accept) begin
        rel_q <= rel_d;
        inv_q <= inv_d;
      end
      if (accept)         vld_q <= 1'b1;
      else if (out_ready) vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign invalid   = inv_q;

  fpc_encode #(.LEGACY(1'b0)) u_flg (
    .rel(rel_q), .bit_zero(flag_zero), .bit_par(flag_parity), .bit_carry(flag_carry)
  );

  fpc_encode #(.LEGACY(1'b1)) u_leg (
    .rel(rel_q), .bit_zero(sw_c3), .bit_par(sw_c2), .bit_carry(sw_c0)
  );
endmodule

// File: rtl/fpc_flags_chk.sv
module fpc_flags_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic         flag_zero,
  input logic         flag_parity,
  input logic         flag_carry,
  input logic         invalid,
  input logic         sw_c0,
  input logic         sw_c2,
  input logic         sw_c3
);
  logic a_nan, acc;
  assign a_nan = (&op_a[W-2 -: EXP_W]) && (|op_a[FRAC_W-1:0]);
  assign acc   = in_valid && in_ready;

  p_unord_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flag_parity |-> (flag_zero && flag_carry));

  p_ordered_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_parity |-> !(flag_zero && flag_carry));

  p_same_bits_eq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_a == op_b && !a_nan) |=> (flag_zero && !flag_carry && !flag_parity));

  p_inv_unord_r9: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> flag_parity);

  p_legacy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_c0 == flag_carry) && (sw_c2 == flag_parity) && (sw_c3 == flag_zero));

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({flag_zero, flag_parity, flag_carry, invalid})));

  p_idle_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> (!out_valid && $stable({flag_zero, flag_parity, flag_carry})));
endmodule

bind fpc_flags fpc_flags_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
  .flag_zero(flag_zero), .flag_parity(flag_parity), .flag_carry(flag_carry),
  .invalid(invalid), .sw_c0(sw_c0), .sw_c2(sw_c2), .sw_c3(sw_c3)
);

// File: tb/fpc_flags_tb.sv
module fpc_flags_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] P_TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] P_1P5  = 64'h3FF8_0000_0000_0000;
  localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] P_ZERO = 64'h0;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN   = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] SUB_A  = 64'h0000_0000_0000_0123;
  localparam logic [63:0] SUB_B  = 64'h0000_0000_0000_0124;
  localparam logic [63:0] N_SUB  = 64'h8000_0000_0000_0005;

  // flag triples as {zero, parity, carry}
  localparam logic [2:0] F_GT = 3'b000, F_LT = 3'b001, F_EQ = 3'b100, F_UN = 3'b111;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, daz = 0, sig_cmp = 0, out_ready = 1;
  logic [63:0] op_a = 0, op_b = 0;
  logic out_valid, flag_zero, flag_parity, flag_carry, invalid, sw_c0, sw_c2, sw_c3;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpc_flags u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .daz(daz), .sig_cmp(sig_cmp),
    .out_valid(out_valid), .out_ready(out_ready),
    .flag_zero(flag_zero), .flag_parity(flag_parity), .flag_carry(flag_carry),
    .invalid(invalid), .sw_c0(sw_c0), .sw_c2(sw_c2), .sw_c3(sw_c3)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One accepted operation; outputs sampled at the following falling edge.
  task automatic run_op(logic [63:0] a, logic [63:0] b, logic d, logic s);
    @(negedge clk);
    op_a = a; op_b = b; daz = d; sig_cmp = s; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic expect_flags(string req, logic [2:0] f);
    check(req, "flags", {flag_zero, flag_parity, flag_carry}, f);
  endtask

  task automatic t_reset;
    check("R11", "reset out_valid", out_valid, 0);
    check("R2", "reset flags", {flag_zero, flag_parity, flag_carry}, F_GT);
    check("R12", "reset in_ready", in_ready, 1);
  endtask

  task automatic t_basic;
    run_op(P_ONE, P_TWO, 0, 0); expect_flags("R3 lt", F_LT);
    check("R10", "legacy lt", {sw_c3, sw_c2, sw_c0}, F_LT);
    check("R11", "valid after one edge", out_valid, 1);
    run_op(P_TWO, P_ONE, 0, 0); expect_flags("R2 gt", F_GT);
    check("R10", "legacy gt", {sw_c3, sw_c2, sw_c0}, F_GT);
    run_op(P_1P5, P_1P5, 0, 0); expect_flags("R3 eq", F_EQ);
    check("R10", "legacy eq", {sw_c3, sw_c2, sw_c0}, F_EQ);
  endtask

  task automatic t_unordered;
    run_op(QNAN, P_ONE, 0, 0); expect_flags("R1 a nan", F_UN);
    check("R10", "legacy un", {sw_c3, sw_c2, sw_c0}, F_UN);
    run_op(P_ONE, SNAN, 0, 0); expect_flags("R1 b nan", F_UN);
  endtask

  task automatic t_sign;
    run_op(N_ONE, N_TWO, 0, 0); expect_flags("R4 -1 vs -2", F_GT);
    run_op(N_TWO, N_ONE, 0, 0); expect_flags("R4 -2 vs -1", F_LT);
    run_op(N_ONE, P_ONE, 0, 0); expect_flags("R4 -1 vs 1", F_LT);
    run_op(P_ZERO, N_ZERO, 0, 0); expect_flags("R5 +0 vs -0", F_EQ);
    run_op(N_ZERO, P_ZERO, 0, 0); expect_flags("R5 -0 vs +0", F_EQ);
  endtask

  task automatic t_subnormal;
    run_op(SUB_A, SUB_B, 0, 0); expect_flags("R6 sub exact", F_LT);
    run_op(N_SUB, P_ZERO, 0, 0); expect_flags("R6 neg sub", F_LT);
    run_op(SUB_A, SUB_B, 1, 0); expect_flags("R7 sub flushed", F_EQ);
    run_op(N_SUB, P_ZERO, 1, 0); expect_flags("R7 neg sub flushed", F_EQ);
    run_op(SUB_A, P_ONE, 1, 0); expect_flags("R7 flushed vs normal", F_LT);
  endtask

  task automatic t_invalid;
    run_op(QNAN, P_ONE, 0, 1); check("R8", "sig qnan", invalid, 1);
    run_op(P_ONE, SNAN, 0, 1); check("R8", "sig snan", invalid, 1);
    run_op(QNAN, P_ONE, 0, 0); check("R9", "quiet qnan", invalid, 0);
    run_op(P_ONE, SNAN, 0, 0); check("R9", "quiet snan", invalid, 1);
    run_op(P_ONE, P_TWO, 0, 1); check("R9", "ordered", invalid, 0);
  endtask

  task automatic t_hold;
    run_op(P_ONE, P_TWO, 0, 0);   // consumed at next edge, nothing new
    @(negedge clk);
    check("R12", "idle valid drops", out_valid, 0);
    expect_flags("R12 held after drop", F_LT);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 0;
    op_a = N_TWO; op_b = N_ONE; daz = 0; sig_cmp = 0; in_valid = 1;
    @(negedge clk);
    expect_flags("R11 stalled first", F_LT);
    check("R12", "in_ready low in stall", in_ready, 0);
    op_a = P_TWO; op_b = P_ONE;      // waits at the input
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R12", "stall valid", out_valid, 1);
      expect_flags("R12 stall stable", F_LT);
    end
    out_ready = 1;                   // consume and accept in same edge
    @(negedge clk);
    in_valid = 0;
    check("R12", "valid across swap", out_valid, 1);
    expect_flags("R12 new after swap", F_GT);
    @(negedge clk);
    check("R12", "drained", out_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    t_reset;
    rst_n = 1;
    t_basic;
    t_unordered;
    t_sign;
    t_subnormal;
    t_invalid;
    t_hold;
    t_backpressure;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule